// File: doc/BRIEF.md
# Single-channel I/O flag and control interface

This block is one I/O channel for a minicomputer-style instruction bus. It holds a control flip-flop, a flag flip-flop, an output data register and an input data register. Each cycle the CPU side may present one I/O instruction strobe with a 6-bit select code, a 4-bit operation code, a clear-flag modifier and write data. The channel decodes only strobes that carry its own select code, except for a clear-control sent to the global select code, which switches the channel off. For skip queries it returns a skip bit in the same cycle. For load and merge instructions it returns read data in the same cycle. All register updates take effect at the next clock edge.

A built-in loopback responder plays the part of the attached device. When control is set, it waits a configurable number of cycles. It then copies the output register into the input register and raises the flag, in the way a real device signals that it has finished. Any transfer or control instruction can also clear the flag in the same instruction, so software can move a word and acknowledge the device with one instruction.

Operation codes: 0 set control, 1 clear control, 2 set flag, 3 clear flag, 4 skip if flag set, 5 skip if flag clear, 6 output from A, 7 output from B, 8 load into A, 9 load into B, 10 merge into A, 11 merge into B. Codes 12 to 15 do nothing.

Top module: `iochan_if`

## Requirements
- R1: An own-select-code set-flag strobe (code 2) without the modifier makes the flag read 1 after the edge. A following skip-if-flag-clear (code 5) then returns skip 0.
- R2: When an own-select-code transfer (codes 6 to 11) carries the clear-flag modifier, the flag reads 0 after the edge. A transfer still returns its read data in that cycle.
- R3: Skip-if-flag-set (code 4) returns skip 1 exactly when the flag is 1. Skip-if-flag-clear (code 5) returns skip 1 exactly when the flag is 0. Every other strobe returns skip 0.
- R4: Set-control (code 0) with the modifier makes the control read 1 and the flag read 0 after the same edge.
- R5: REPLY_DLY clock edges after a set-control strobe is taken (default 3), with control still set, the responder sets the flag and copies the output register into the input register, once. A clear-control before then cancels the reply.
- R6: Clear-control (code 1) on select code GLOBAL_SC (default 0) clears this channel's control and leaves the flag unchanged.
- R7: Strobes with any other foreign select code change neither control, flag nor data, and return skip 0 and read data 0.
- R8: Load and merge (codes 8 to 11) return the input register on io_rdata. All other strobes return 0.
- R9: Reset clears control, flag and both data registers.
- R10: When a clear of the flag and a set of the flag happen in the same cycle, the clear wins, so set-flag with the modifier leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | An I/O instruction strobe is present this cycle |
| io_sel | input | 6 | Select code of the strobe |
| io_op | input | 4 | Operation code (see list above) |
| io_clf | input | 1 | Clear-flag modifier |
| io_wdata | input | 16 | Accumulator word for output instructions |
| io_skip | output | 1 | Skip answer for the current strobe |
| io_rdata | output | 16 | Read data for load and merge instructions |
| ctl_q | output | 1 | Control flip-flop |
| flg_q | output | 1 | Flag flip-flop |

## Verification
Each transfer code is tried with the modifier after the flag has first been set and confirmed set. This separates a flag clear caused by the modifier from a flag that was never set. The loopback is tried in two ways: with control left on until the reply, and with control cleared one cycle before the reply is due. The first exposes an off-by-one in the delay; the second shows whether cancellation works. Foreign-code strobes write a distinctive word and are followed by a local reply, so a foreign write that leaked into the output register would show up in the echoed data. The global clear is sent with the flag set, which separates "clears control" from "clears everything".

// File: rtl/iochan_pkg.sv
package iochan_pkg;

  typedef enum logic [3:0] {
    OP_STC = 4'd0,
    OP_CLC = 4'd1,
    OP_STF = 4'd2,
    OP_CLF = 4'd3,
    OP_SFS = 4'd4,
    OP_SFC = 4'd5,
    OP_OTA = 4'd6,
    OP_OTB = 4'd7,
    OP_LIA = 4'd8,
    OP_LIB = 4'd9,
    OP_MIA = 4'd10,
    OP_MIB = 4'd11
  } io_op_e;

  // skip answer for a decoded own-channel operation
  function automatic logic skip_of(input logic [3:0] op, input logic flag);
    case (op)
      OP_SFS:  skip_of = flag;
      OP_SFC:  skip_of = ~flag;
      default: skip_of = 1'b0;
    endcase
  endfunction

  function automatic logic is_read(input logic [3:0] op);
    is_read = (op == OP_LIA) || (op == OP_LIB) || (op == OP_MIA) || (op == OP_MIB);
  endfunction

  function automatic logic is_write(input logic [3:0] op);
    is_write = (op == OP_OTA) || (op == OP_OTB);
  endfunction

endpackage

// File: rtl/iochan_decode.sv
module iochan_decode
  import iochan_pkg::*;
#(
  parameter int SC_W      = 6,
  parameter int MY_SC     = 10,
  parameter int GLOBAL_SC = 0
) (
  input  logic            io_valid,
  input  logic [SC_W-1:0] io_sel,
  input  logic [3:0]      io_op,
  input  logic            io_clf,
  output logic            evt_hit,
  output logic            evt_set_ctl,
  output logic            evt_clr_ctl,
  output logic            evt_set_flg,
  output logic            evt_clr_flg,
  output logic            evt_write,
  output logic            evt_read,
  output logic            evt_gclr
);
  localparam logic [SC_W-1:0] OWN_CODE = SC_W'(MY_SC);
  localparam logic [SC_W-1:0] GLB_CODE = SC_W'(GLOBAL_SC);

  always_comb begin
    evt_hit     = io_valid && (io_sel == OWN_CODE);
    evt_set_ctl = evt_hit && (io_op == OP_STC);
    evt_clr_ctl = evt_hit && (io_op == OP_CLC);
    evt_set_flg = evt_hit && (io_op == OP_STF);
    evt_clr_flg = evt_hit && (io_clf || (io_op == OP_CLF));
    evt_write   = evt_hit && is_write(io_op);
    evt_read    = evt_hit && is_read(io_op);
    evt_gclr    = io_valid && (io_sel == GLB_CODE) && (io_op == OP_CLC);
  end
endmodule

// File: rtl/iochan_flagctl.sv
module iochan_flagctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ctl,
  input  logic clr_ctl,
  input  logic set_flg,
  input  logic clr_flg,
  output logic ctl_q,
  output logic flg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      if (clr_ctl)      ctl_q <= 1'b0;
      else if (set_ctl) ctl_q <= 1'b1;
      // a clear request beats any simultaneous set
      if (clr_flg)      flg_q <= 1'b0;
      else if (set_flg) flg_q <= 1'b1;
    end
  end
endmodule

// File: rtl/iochan_loopback.sv
module iochan_loopback #(
  parameter int DW        = 16,
  parameter int REPLY_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          disarm,
  input  logic [DW-1:0] out_word,
  output logic          fire,
  output logic [DW-1:0] in_word
);
  localparam int CW = $clog2(REPLY_DLY + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(REPLY_DLY - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  assign fire = armed && (cnt == '0) && !disarm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      in_word <= '0;
    end else begin
      if (disarm) begin
        armed <= 1'b0;
      end else if (arm) begin
        armed <= 1'b1;
        cnt   <= LOAD_VAL;
      end else if (fire) begin
        armed   <= 1'b0;
        in_word <= out_word;
      end else if (armed) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/iochan_if.sv
module iochan_if
  import iochan_pkg::*;
#(
  parameter int SC_W      = 6,
  parameter int DW        = 16,
  parameter int MY_SC     = 10,
  parameter int GLOBAL_SC = 0,
  parameter int REPLY_DLY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_valid,
  input  logic [SC_W-1:0] io_sel,
  input  logic [3:0]      io_op,
  input  logic            io_clf,
  input  logic [DW-1:0]   io_wdata,
  output logic            io_skip,
  output logic [DW-1:0]   io_rdata,
  output logic            ctl_q,
  output logic            flg_q
);
  logic          evt_hit, evt_set_ctl, evt_clr_ctl, evt_set_flg, evt_clr_flg;
  logic          evt_write, evt_read, evt_gclr, evt_fire, evt_ctl_off;
  logic [DW-1:0] out_reg, in_reg;

  iochan_decode #(.SC_W(SC_W), .MY_SC(MY_SC), .GLOBAL_SC(GLOBAL_SC)) u_dec (
    .io_valid(io_valid), .io_sel(io_sel), .io_op(io_op), .io_clf(io_clf),
    .evt_hit(evt_hit), .evt_set_ctl(evt_set_ctl), .evt_clr_ctl(evt_clr_ctl),
    .evt_set_flg(evt_set_flg), .evt_clr_flg(evt_clr_flg),
    .evt_write(evt_write), .evt_read(evt_read), .evt_gclr(evt_gclr)
  );

  assign evt_ctl_off = evt_clr_ctl || evt_gclr;

  iochan_flagctl u_fc (
    .clk(clk), .rst_n(rst_n),
    .set_ctl(evt_set_ctl), .clr_ctl(evt_ctl_off),
    .set_flg(evt_set_flg || evt_fire), .clr_flg(evt_clr_flg),
    .ctl_q(ctl_q), .flg_q(flg_q)
  );

  iochan_loopback #(.DW(DW), .REPLY_DLY(REPLY_DLY)) u_lb (
    .clk(clk), .rst_n(rst_n),
    .arm(evt_set_ctl), .disarm(evt_ctl_off),
    .out_word(out_reg), .fire(evt_fire), .in_word(in_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         out_reg <= '0;
    else if (evt_write) out_reg <= io_wdata;
  end

  assign io_skip  = evt_hit && skip_of(io_op, flg_q);
  assign io_rdata = evt_read ? in_reg : '0;
endmodule

// File: rtl/iochan_if_chk.sv
module iochan_if_chk
  import iochan_pkg::*;
#(
  parameter int SC_W = 6,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      io_op,
  input logic            io_clf,
  input logic            io_skip,
  input logic [DW-1:0]   io_rdata,
  input logic            ctl_q,
  input logic            flg_q,
  input logic            evt_hit,
  input logic            evt_fire,
  input logic            evt_gclr
);
  AST_STF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && io_op == OP_STF && !io_clf) |=> flg_q);                     // R1
  AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && io_clf) |=> !flg_q);                                         // R2
  AST_SFS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && io_op == OP_SFS) |-> (io_skip == flg_q));                    // R3
  AST_SFC_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && io_op == OP_SFC) |-> (io_skip == !flg_q));                   // R3
  AST_STC_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && io_op == OP_STC && io_clf) |=> (ctl_q && !flg_q));          // R4
  AST_REPLY_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |-> ctl_q);                                                     // R5
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gclr |=> !ctl_q);                                                    // R6
  AST_FOREIGN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_hit && !evt_gclr && !evt_fire) |=> ($stable(ctl_q) && $stable(flg_q))); // R7
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_hit |-> (!io_skip && io_rdata == '0));                             // R7
endmodule

bind iochan_if iochan_if_chk #(.SC_W(SC_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_op(io_op), .io_clf(io_clf),
  .io_skip(io_skip), .io_rdata(io_rdata), .ctl_q(ctl_q), .flg_q(flg_q),
  .evt_hit(evt_hit), .evt_fire(evt_fire), .evt_gclr(evt_gclr)
);

// File: tb/sim_iochan_if.sv
module sim_iochan_if;
  localparam logic [5:0] OWN = 6'd10;
  localparam logic [5:0] GLB = 6'd0;
  localparam logic [5:0] OTH = 6'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic [5:0]  io_sel = '0;
  logic [3:0]  io_op = '0;
  logic        io_clf = 1'b0;
  logic [15:0] io_wdata = '0;
  logic        io_skip;
  logic [15:0] io_rdata;
  logic        ctl_q, flg_q;

  int checks = 0;
  int fails  = 0;

  bit          q_skip[$];
  logic [15:0] q_rd[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  iochan_if u0 (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_sel(io_sel),
    .io_op(io_op), .io_clf(io_clf), .io_wdata(io_wdata),
    .io_skip(io_skip), .io_rdata(io_rdata), .ctl_q(ctl_q), .flg_q(flg_q)
  );

  // monitor: compare combinational answers mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (io_valid) begin
      checks++;
      if (q_tag.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected strobe, actual none expected");
      end else begin
        bit          es;
        logic [15:0] er;
        string       t;
        es = q_skip.pop_front();
        er = q_rd.pop_front();
        t  = q_tag.pop_front();
        if (io_skip !== es || io_rdata !== er) begin
          fails++;
          $display("FAIL %s: actual skip=%0b rdata=%h expected skip=%0b rdata=%h",
                   t, io_skip, io_rdata, es, er);
        end
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [5:0] sel, input logic c,
                       input logic [15:0] wd, input bit es, input logic [15:0] er,
                       input string tag);
    @(posedge clk); #2;
    io_valid = 1'b1; io_op = op; io_sel = sel; io_clf = c; io_wdata = wd;
    q_skip.push_back(es); q_rd.push_back(er); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      io_valid = 1'b0; io_clf = 1'b0;
    end
  endtask

  task automatic chk(input logic ec, input logic ef, input string tag);
    checks++;
    if (ctl_q !== ec || flg_q !== ef) begin
      fails++;
      $display("FAIL %s: actual ctl=%0b flag=%0b expected ctl=%0b flag=%0b",
               tag, ctl_q, flg_q, ec, ef);
    end
  endtask

  task automatic finish_run();
    if (q_tag.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q_tag.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(0, 0, "R9 reset state");
    issue(4'd8, OWN, 0, 0, 0, 16'h0000, "R9 input register cleared");
    idle(1);

    // R1 / R3: set flag then query both skips
    issue(4'd2, OWN, 0, 0, 0, 0, "R8 set-flag returns no data");
    issue(4'd5, OWN, 0, 0, 0, 0, "R1 skip-if-clear after set");
    issue(4'd4, OWN, 0, 0, 1, 0, "R3 skip-if-set with flag 1");
    idle(1);
    chk(0, 1, "R1 flag set");
    issue(4'd3, OWN, 0, 0, 0, 0, "R3 clear flag");
    issue(4'd5, OWN, 0, 0, 1, 0, "R3 skip-if-clear with flag 0");
    issue(4'd4, OWN, 0, 0, 0, 0, "R3 skip-if-set with flag 0");
    idle(1);
    chk(0, 0, "R3 flag cleared");

    // R2: every transfer code with the modifier
    for (int op = 6; op <= 11; op++) begin
      issue(4'd2, OWN, 0, 0, 0, 0, "R2 arm flag");
      issue(4'd4, OWN, 0, 0, 1, 0, "R2 flag set before transfer");
      issue(4'(op), OWN, 1, 16'h1111 * 16'(op), 0, 16'h0000, "R2 transfer with modifier");
      idle(1);
      chk(0, 0, "R2 flag clear after transfer");
    end

    // R4 / R5: output, then set control with modifier, wait for reply
    issue(4'd6, OWN, 0, 16'hA5C3, 0, 0, "R8 output returns no data");
    issue(4'd2, OWN, 0, 0, 0, 0, "R4 preset flag");
    issue(4'd0, OWN, 1, 0, 0, 0, "R4 set control with modifier");
    idle(1);
    chk(1, 0, "R4 control on flag off");
    idle(2);
    chk(1, 0, "R5 no reply before delay");
    idle(1);
    chk(1, 1, "R5 reply after delay");
    issue(4'd9, OWN, 0, 0, 0, 16'hA5C3, "R5 echoed word on load B");
    issue(4'd10, OWN, 0, 0, 0, 16'hA5C3, "R8 merge A returns input word");
    issue(4'd11, OWN, 0, 0, 0, 16'hA5C3, "R8 merge B returns input word");
    issue(4'd2, OWN, 1, 0, 0, 0, "R10 set-flag with modifier");
    idle(1);
    chk(1, 0, "R10 clear wins");
    idle(5);
    chk(1, 0, "R5 reply happens once");

    // R6: global clear-control leaves flag alone
    issue(4'd2, OWN, 0, 0, 0, 0, "R6 preset flag");
    issue(4'd1, GLB, 0, 0, 0, 0, "R6 global clear-control");
    idle(1);
    chk(0, 1, "R6 control off flag kept");

    // R5 cancel: clear control before reply is due
    issue(4'd7, OWN, 0, 16'h0F0F, 0, 0, "R5 output new word");
    issue(4'd3, OWN, 0, 0, 0, 0, "R5 clear flag");
    issue(4'd0, OWN, 0, 0, 0, 0, "R5 set control");
    idle(1);
    issue(4'd1, OWN, 0, 0, 0, 0, "R5 clear control early");
    idle(5);
    chk(0, 0, "R5 cancelled reply");
    issue(4'd8, OWN, 0, 0, 0, 16'hA5C3, "R5 no echo after cancel");

    // R7: foreign select code
    issue(4'd2, OWN, 0, 0, 0, 0, "R7 preset flag");
    issue(4'd3, OTH, 0, 0, 0, 0, "R7 foreign clear flag");
    issue(4'd0, OTH, 1, 0, 0, 0, "R7 foreign set control");
    issue(4'd6, OTH, 0, 16'h1234, 0, 0, "R7 foreign output");
    issue(4'd4, OTH, 0, 0, 0, 0, "R7 foreign skip query");
    issue(4'd8, OTH, 0, 0, 0, 0, "R7 foreign load");
    idle(5);
    chk(0, 1, "R7 state untouched");
    issue(4'd0, OWN, 0, 0, 0, 0, "R7 own set control");
    idle(5);
    chk(1, 1, "R7 local reply");
    issue(4'd8, OWN, 0, 0, 0, 16'h0F0F, "R7 output register kept");
    idle(2);

    finish_run();
  end
endmodule